// File: doc/BRIEF.md
# Dual Reference Supervisor

This block watches two incoming reference pulse trains, sampled in a fast system clock, and decides which one a downstream phase-locked loop should follow. Each reference is passed through a synchronizer. A rising edge restarts that reference's silence counter. A reference counts as usable only while its counter has not reached the loss limit and its external out-of-range flag is low.

A select input names the preferred reference. The block turns the usability of both references, a force-free-run request and an external lock-loss flag into four outputs: a registered mode code, a combined alarm, a free-run status flag and a gated true/complement output pair. When the select input changes, the lock-loss contribution to the alarm is suppressed for a qualification interval. This gives the loop time to settle on the new reference. The loss limit and the qualification interval are parameters counted in system clock cycles.

Top module: `dual_ref_supervisor`

## Requirements
- R1: With both references usable and no force, select 0 gives mode 2'b01 (tracking A), select 1 gives mode 2'b10 (tracking B), and both alarm and free_run are 0.
- R2: When force_free is 1, the next registered outputs are mode 2'b00, free_run 1 and alarm 0, whatever the references are doing.
- R3: While rst is 1, the outputs become mode 2'b00, free_run 1 and alarm 0.
- R4: When neither reference is usable and there is no force, the block enters mode 2'b00 with free_run 1 and alarm 1.
- R5: When the selected reference is unusable and the other is usable, mode is 2'b11 (unstable), alarm is 1 and free_run is 0.
- R6: Losing only the unselected reference has no effect: the mode stays on the selected reference and alarm stays 0.
- R7: A reference whose rising edges are spaced fewer than LOSS_CYCLES system clocks apart stays usable. A reference with no rising edge for LOSS_CYCLES clocks, plus the synchronizer latency, becomes unusable.
- R8: A reference whose range_bad input is 1 is treated as unusable for both selection and alarm.
- R9: While a reference is tracked and no qualification interval is running, lock_lost = 1 drives alarm to 1.
- R10: For BLANK_CYCLES clocks after any change of sel_b, lock_lost is kept off the alarm.
- R11: When out_off is 1, out_p is 0 and out_n is 1. When out_off is 0, out_p follows osc_in and out_n is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 1 | Reference A pulse train (asynchronous) |
| ref_b | input | 1 | Reference B pulse train (asynchronous) |
| sel_b | input | 1 | 0 prefers reference A, 1 prefers reference B |
| force_free | input | 1 | 1 requests free-run |
| range_bad_a | input | 1 | Reference A frequency out of range |
| range_bad_b | input | 1 | Reference B frequency out of range |
| lock_lost | input | 1 | Lock-loss flag from the loop |
| out_off | input | 1 | 1 disables the output pair |
| osc_in | input | 1 | Oscillator signal to pass through |
| out_p | output | 1 | True output |
| out_n | output | 1 | Complement output |
| alarm | output | 1 | Combined loss-of-reference / loss-of-lock alarm |
| free_run | output | 1 | Free-run status |
| mode | output | 2 | 00 free-run, 01 tracking A, 10 tracking B, 11 unstable |

## Verification
A table of steady-state patterns runs through each combination of running or silent references, each select value, force, the range flags and lock loss.

- Silence on the unselected reference tells R6 apart from R5.
- A force with both references silent tells the forced alarm-free state apart from automatic free-run.

Directed tests then cover the following:

- **Edge spacing.** One pattern keeps edges just inside the loss limit. Another stops the pulses and samples on both sides of the limit.
- **Qualification window.** The alarm is checked a few cycles after a select change and again after the window ends.
- **Reset.** Reset is applied while the references are running.
- **Output pair.** The pair is checked in both enable states.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_LOCK_A   = 2'b01,
        MODE_LOCK_B   = 2'b10,
        MODE_UNSTABLE = 2'b11
    } refsel_mode_e;

    typedef struct packed {
        refsel_mode_e mode;
        logic         alarm;
        logic         free_run;
    } refsel_verdict_t;

    localparam refsel_verdict_t VERDICT_RESET = '{mode: MODE_FREE, alarm: 1'b0, free_run: 1'b1};

    // Priority: force, then both lost, then selected lost, then tracking.
    function automatic refsel_verdict_t refsel_judge(
        input logic force_req,
        input logic use_a,
        input logic use_b,
        input logic pick_b,
        input logic lol,
        input logic blank
    );
        refsel_verdict_t v;
        logic pick_ok;
        pick_ok = pick_b ? use_b : use_a;
        if (force_req) begin
            v = VERDICT_RESET;
        end else if (!use_a && !use_b) begin
            v = '{mode: MODE_FREE, alarm: 1'b1, free_run: 1'b1};
        end else if (!pick_ok) begin
            v = '{mode: MODE_UNSTABLE, alarm: 1'b1, free_run: 1'b0};
        end else begin
            v.mode     = pick_b ? MODE_LOCK_B : MODE_LOCK_A;
            v.alarm    = lol && !blank;
            v.free_run = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/refsel_activity_mon.sv
module refsel_activity_mon #(
    parameter int LOSS_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic range_bad,
    output logic usable
);
    localparam int CW = $clog2(LOSS_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] chain;
    logic                 rise;
    logic [CW-1:0]        quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], ref_in};
    end

    assign rise = chain[SYNC_STAGES-1] && !chain[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst)                    quiet_cnt <= LIMIT;
        else if (rise)              quiet_cnt <= '0;
        else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign usable = (quiet_cnt != LIMIT) && !range_bad;

endmodule

// File: rtl/refsel_qual_timer.sv
module refsel_qual_timer #(
    parameter int BLANK_CYCLES = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_b,
    output logic blank
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);

    logic          sel_seen;
    logic          sel_moved;
    logic [CW-1:0] left;

    assign sel_moved = (sel_b != sel_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_seen <= 1'b0;
            left     <= '0;
        end else begin
            sel_seen <= sel_b;
            if (sel_moved)        left <= CW'(BLANK_CYCLES);
            else if (left != '0)  left <= left - 1'b1;
        end
    end

    assign blank = sel_moved || (left != '0);

endmodule

// File: rtl/refsel_decide.sv
module refsel_decide
    import refsel_pkg::*;
(
    input  logic            force_req,
    input  logic            use_a,
    input  logic            use_b,
    input  logic            pick_b,
    input  logic            lol,
    input  logic            blank,
    output refsel_verdict_t verdict
);
    always_comb begin
        verdict = refsel_judge(force_req, use_a, use_b, pick_b, lol, blank);
    end
endmodule

// File: rtl/dual_ref_supervisor.sv
module dual_ref_supervisor
    import refsel_pkg::*;
#(
    parameter int LOSS_CYCLES  = 20,
    parameter int BLANK_CYCLES = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_a,
    input  logic       ref_b,
    input  logic       sel_b,
    input  logic       force_free,
    input  logic       range_bad_a,
    input  logic       range_bad_b,
    input  logic       lock_lost,
    input  logic       out_off,
    input  logic       osc_in,
    output logic       out_p,
    output logic       out_n,
    output logic       alarm,
    output logic       free_run,
    output logic [1:0] mode
);
    localparam int NREF = 2;

    logic [NREF-1:0] ref_vec;
    logic [NREF-1:0] bad_vec;
    logic [NREF-1:0] use_vec;
    logic            use_a;
    logic            use_b;
    logic            blank;
    refsel_verdict_t next_v;
    refsel_verdict_t cur_v;

    assign ref_vec = {ref_b, ref_a};
    assign bad_vec = {range_bad_b, range_bad_a};

    for (genvar i = 0; i < NREF; i++) begin : g_mon
        refsel_activity_mon #(
            .LOSS_CYCLES (LOSS_CYCLES),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_mon (
            .clk       (clk),
            .rst       (rst),
            .ref_in    (ref_vec[i]),
            .range_bad (bad_vec[i]),
            .usable    (use_vec[i])
        );
    end

    assign use_a = use_vec[0];
    assign use_b = use_vec[1];

    refsel_qual_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .sel_b (sel_b),
        .blank (blank)
    );

    refsel_decide u_decide (
        .force_req (force_free),
        .use_a     (use_a),
        .use_b     (use_b),
        .pick_b    (sel_b),
        .lol       (lock_lost),
        .blank     (blank),
        .verdict   (next_v)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_v <= VERDICT_RESET;
        else     cur_v <= next_v;
    end

    assign mode     = cur_v.mode;
    assign alarm    = cur_v.alarm;
    assign free_run = cur_v.free_run;

    assign out_p = out_off ? 1'b0 : osc_in;
    assign out_n = out_off ? 1'b1 : !osc_in;

endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_b,
    input logic       force_free,
    input logic       use_a,
    input logic       use_b,
    input logic       out_off,
    input logic       out_p,
    input logic       out_n,
    input logic       alarm,
    input logic       free_run,
    input logic [1:0] mode
);
    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mode == 2'b00 && free_run && !alarm));

    // R2
    force_free_chk: assert property (@(posedge clk) disable iff (rst)
        force_free |=> (mode == 2'b00 && free_run && !alarm));

    // R4
    both_lost_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_free && !use_a && !use_b) |=> (mode == 2'b00 && free_run && alarm));

    // R5
    unstable_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |-> (alarm && !free_run));

    // R10
    switch_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_b != $past(sel_b)) |=> !(alarm && (mode == 2'b01 || mode == 2'b10)));

    // R11
    out_hold_chk: assert property (@(posedge clk)
        out_off |-> (!out_p && out_n));

    // R1
    track_no_fr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 || mode == 2'b10) |-> !free_run);
endmodule

bind dual_ref_supervisor refsel_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_b      (sel_b),
    .force_free (force_free),
    .use_a      (use_a),
    .use_b      (use_b),
    .out_off    (out_off),
    .out_p      (out_p),
    .out_n      (out_n),
    .alarm      (alarm),
    .free_run   (free_run),
    .mode       (mode)
);

// File: tb/dual_ref_supervisor_bench.sv
`timescale 1ns/1ps
module dual_ref_supervisor_bench;
    localparam int LOSS  = 20;
    localparam int BLANK = 30;
    localparam int NVEC  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_a = 1'b0, ref_b = 1'b0;
    logic sel_b = 1'b0, force_free = 1'b0;
    logic range_bad_a = 1'b0, range_bad_b = 1'b0;
    logic lock_lost = 1'b0, out_off = 1'b0, osc_in = 1'b0;
    logic out_p, out_n, alarm, free_run;
    logic [1:0] mode;

    logic run_a = 1'b0, run_b = 1'b0;
    int   half_a = 4;
    int   errors = 0, checks = 0;

    always #2 clk = ~clk;

    dual_ref_supervisor #(.LOSS_CYCLES(LOSS), .BLANK_CYCLES(BLANK)) u_dual_ref_supervisor (
        .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b),
        .force_free(force_free), .range_bad_a(range_bad_a), .range_bad_b(range_bad_b),
        .lock_lost(lock_lost), .out_off(out_off), .osc_in(osc_in),
        .out_p(out_p), .out_n(out_n), .alarm(alarm), .free_run(free_run), .mode(mode)
    );

    // reference generators, driven on the falling edge
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % (2 * half_a);
            ref_a = run_a && (ph < half_a);
        end
    end
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 8;
            ref_b = run_b && (ph < 4);
        end
    end

    // {req, run_a, run_b, sel, force, bad_a, bad_b, lol, mode, alarm, fr}
    localparam logic [14:0] VEC [NVEC] = '{
        {4'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0,1'b0},
        {4'd1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b10,1'b0,1'b0},
        {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b10,1'b0,1'b0},
        {4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11,1'b1,1'b0},
        {4'd4, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b1},
        {4'd2, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1},
        {4'd2, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 2'b00,1'b0,1'b1},
        {4'd8, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11,1'b1,1'b0},
        {4'd8, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 2'b00,1'b1,1'b1},
        {4'd8, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b01,1'b0,1'b0},
        {4'd9, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 2'b01,1'b1,1'b0},
        {4'd9, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 2'b10,1'b1,1'b0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R3: outputs held in reset
        wait_cyc(5);
        chk("R3 reset", {mode, alarm, free_run}, 4'b0001);
        rst = 1'b0;

        // table of steady-state patterns
        for (int i = 0; i < NVEC; i++) begin
            {run_a, run_b, sel_b, force_free, range_bad_a, range_bad_b, lock_lost} = VEC[i][10:4];
            wait_cyc(70);
            chk(req_name(VEC[i][14:11]), {mode, alarm, free_run}, VEC[i][3:0]);
        end

        // R7: edges every 16 clocks (< LOSS) keep reference A usable
        {run_a, run_b, sel_b, force_free, range_bad_a, range_bad_b, lock_lost} = 7'b1100000;
        half_a = 8;
        wait_cyc(80);
        chk("R7 slow edges", {mode, alarm, free_run}, 4'b0100);
        half_a = 4;
        wait_cyc(20);
        // R7: stop A; still usable before the limit, lost after it
        run_a = 1'b0;
        wait_cyc(10);
        chk("R7 before limit", {mode, alarm, free_run}, 4'b0100);
        wait_cyc(20);
        chk("R7 after limit", {mode, alarm, free_run}, 4'b1110);

        // R10: lock loss blanked right after a switch, visible after the window
        run_a = 1'b1;
        lock_lost = 1'b1;
        wait_cyc(70);
        chk("R9 lol visible", {mode, alarm, free_run}, 4'b0110);
        sel_b = 1'b1;
        wait_cyc(3);
        chk("R10 blanked", {mode, alarm, free_run}, 4'b1000);
        wait_cyc(BLANK + 10);
        chk("R10 after window", {mode, alarm, free_run}, 4'b1010);
        lock_lost = 1'b0;

        // R3: reset while references run
        rst = 1'b1;
        wait_cyc(2);
        chk("R3 reset mid-run", {mode, alarm, free_run}, 4'b0001);
        rst = 1'b0;

        // R11: output pair
        out_off = 1'b1; osc_in = 1'b1; #1;
        chk("R11 disabled hi", {2'b00, out_p, out_n}, 4'b0001);
        osc_in = 1'b0; #1;
        chk("R11 disabled lo", {2'b00, out_p, out_n}, 4'b0001);
        out_off = 1'b0; osc_in = 1'b1; #1;
        chk("R11 enabled hi", {2'b00, out_p, out_n}, 4'b0010);
        osc_in = 1'b0; #1;
        chk("R11 enabled lo", {2'b00, out_p, out_n}, 4'b0001);

        finish_run();
    end
endmodule